// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel with six operating modes: a one-shot that raises its output at terminal count, a gate-triggered one-shot, a rate generator, a square-wave generator, and two strobe modes. The first strobe mode starts when the count is loaded. The second starts on a gate edge. Each mode drives its own waveform on a single output. A separate register interface presents a load strobe together with the initial value, the mode code and a BCD select. The channel advances on a count-enable tick and takes a gate input.

Counting is either binary or four-digit BCD. A loaded value of zero means the largest possible count. The one-shot and strobe modes run on past zero and wrap around. The periodic modes reload the initial value at the end of each period. In some modes the gate level pauses counting. In other modes a rising gate edge restarts the count.

Top module: `interval_counter`

## Requirements
- R1: After reset the count reads 0, the output is high, and ticks and gate activity have no effect until the first load.
- R2: Mode 0 (one-shot). A load sets the count to the initial value and drives the output low. Each tick decrements the count. The output rises on the tick that brings the count to zero and stays high while the count wraps (0 to FFFF binary) and keeps running.
- R3: In modes 0 and 4, a low gate holds the count and the output. A rising gate edge does not restart the count in these modes.
- R4: Mode 1 (gate-triggered one-shot). After a load the channel waits with the output high and does not count. On a rising gate edge it loads the initial value and drives the output low. The output goes high on the tick that reaches zero, and the count then wraps and keeps running.
- R5: Mode 2 (rate generator). On a tick taken with the count at 1, the channel reloads the initial value and raises the output for that one tick period. Every other tick decrements the count with the output low. The first pulse comes N ticks after the load.
- R6: Mode 3 (square wave, counts of 2 or more). Each tick decrements the count by two. A half period ends on a tick taken with the count at 1 or 2; that tick toggles the output and reloads. The high half lasts ceil(N/2) ticks and the low half lasts floor(N/2) ticks. For odd N the low half starts from N-1.
- R7: Modes 4 (started by load) and 5 (started by a rising gate edge). The output is low and goes high for exactly one tick period when the count first reaches zero. It then stays low while the count wraps.
- R8: In modes 1, 2, 3 and 5, a rising gate edge reloads the initial value and restarts the current mode's waveform from its start.
- R9: An initial value of 0 counts as 65536 ticks in binary and 10000 ticks in BCD.
- R10: With BCD selected and a valid BCD value loaded, every digit of the count stays at or below 9. Decrements borrow in decimal, and 0000 wraps to 9999.
- R11: A load that repeats the current mode and number base in modes 1, 2, 3 or 5 only replaces the reload value. It takes effect at the next reload. A load in modes 0 or 4 restarts at once.
- R12: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe for initial value, mode and base |
| init_i | input | 16 | Initial count value |
| mode_i | input | 3 | Mode code |
| bcd_i | input | 1 | 1 selects BCD counting |
| gate_i | input | 1 | Gate input |
| tick_i | input | 1 | Count-enable tick |
| count_o | output | 16 | Current count value |
| out_o | output | 1 | Channel output waveform |

## Verification
Every result is registered once. A load, a gate edge or a tick presented before a rising clock edge changes count_o and out_o at that edge, so the result is due one clock after the stimulus. The bench drives inputs on the falling edge and compares outputs on the next falling edge. This places each comparison exactly one register stage after the stimulus it checks. For the maximum-count cases the bench counts ticks and expects the pulse on exactly the 65536th tick in binary and the 10000th tick in BCD.

// File: rtl/interval_counter_pkg.sv
package interval_counter_pkg;

    typedef enum logic [2:0] {
        M_ONESHOT  = 3'd0,
        M_RETRIG   = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } ic_mode_e;

    // Codes 6 and 7 alias the two periodic modes.
    function automatic ic_mode_e fold_mode(input logic [2:0] code);
        if (code[2] && code[1]) return ic_mode_e'({1'b0, code[1:0]});
        return ic_mode_e'(code);
    endfunction

    // Modes that restart on a rising gate edge.
    function automatic logic is_edge_mode(input ic_mode_e m);
        return (m == M_RETRIG) || (m == M_RATE) ||
               (m == M_SQUARE) || (m == M_HWSTROBE);
    endfunction

    // Modes in which a low gate pauses counting.
    function automatic logic is_level_mode(input ic_mode_e m);
        return (m == M_ONESHOT) || (m == M_SWSTROBE);
    endfunction

endpackage

// File: rtl/ic_dec.sv
module ic_dec #(
    parameter int DIGITS = 4,
    parameter int STEP   = 1,
    localparam int CW    = 4 * DIGITS
) (
    input  logic [CW-1:0] value_i,
    input  logic          bcd_i,
    output logic [CW-1:0] value_o
);
    logic [CW-1:0] bin_res;
    logic [CW-1:0] dec_res;
    logic [DIGITS:0] borrow;

    assign bin_res   = value_i - CW'(STEP);
    assign borrow[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] sub;
        logic [4:0] diff;
        if (g == 0) begin : g_lsd
            assign sub = 5'(STEP);
        end else begin : g_upper
            assign sub = {4'b0, borrow[g]};
        end
        always_comb begin
            diff = {1'b0, value_i[4*g +: 4]} - sub;
            if (diff[4]) begin
                dec_res[4*g +: 4] = 4'(diff + 5'd10);
                borrow[g+1]       = 1'b1;
            end else begin
                dec_res[4*g +: 4] = diff[3:0];
                borrow[g+1]       = 1'b0;
            end
        end
    end

    assign value_o = bcd_i ? dec_res : bin_res;
endmodule

// File: rtl/ic_gate_edge.sv
module ic_gate_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end

    assign rise_o = gate_i && !gate_q;
endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import interval_counter_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CW    = 4 * DIGITS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] init_i,
    input  logic [2:0]    mode_i,
    input  logic          bcd_i,
    input  logic          gate_i,
    input  logic          tick_i,
    output logic [CW-1:0] count_o,
    output logic          out_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] init;
        ic_mode_e      mode;
        logic          bcd;
        logic          valid;
        logic          out;
        logic          run;
        logic          fired;
    } ic_state_t;

    ic_state_t st_d, st_q;

    logic          gate_rise;
    logic [CW-1:0] cnt_dn1, cnt_dn2, init_dn1;
    ic_mode_e      new_mode;
    logic          same_prog;
    logic          level_ok;
    logic          half_end;

    ic_gate_edge u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .gate_i (gate_i),
        .rise_o (gate_rise)
    );

    ic_dec #(.DIGITS(DIGITS), .STEP(1)) u_dec1 (
        .value_i (st_q.cnt), .bcd_i (st_q.bcd), .value_o (cnt_dn1)
    );
    ic_dec #(.DIGITS(DIGITS), .STEP(2)) u_dec2 (
        .value_i (st_q.cnt), .bcd_i (st_q.bcd), .value_o (cnt_dn2)
    );
    ic_dec #(.DIGITS(DIGITS), .STEP(1)) u_dec_init (
        .value_i (st_q.init), .bcd_i (st_q.bcd), .value_o (init_dn1)
    );

    always_comb begin
        st_d      = st_q;
        new_mode  = fold_mode(mode_i);
        same_prog = st_q.valid && (new_mode == st_q.mode) &&
                    (bcd_i == st_q.bcd) && is_edge_mode(new_mode);
        level_ok  = gate_i || !is_level_mode(st_q.mode);
        half_end  = (st_q.cnt == CW'(1)) || (st_q.cnt == CW'(2));

        if (load_i) begin
            st_d.init  = init_i;
            st_d.valid = 1'b1;
            if (!same_prog) begin
                st_d.mode  = new_mode;
                st_d.bcd   = bcd_i;
                st_d.cnt   = init_i;
                st_d.fired = 1'b0;
                unique case (new_mode)
                    M_ONESHOT:  begin st_d.out = 1'b0; st_d.run = 1'b1; end
                    M_RETRIG:   begin st_d.out = 1'b1; st_d.run = 1'b0; end
                    M_RATE:     begin st_d.out = 1'b0; st_d.run = 1'b1; end
                    M_SQUARE:   begin st_d.out = 1'b1; st_d.run = 1'b1; end
                    M_SWSTROBE: begin st_d.out = 1'b0; st_d.run = 1'b1; end
                    M_HWSTROBE: begin st_d.out = 1'b0; st_d.run = 1'b0; end
                    default:    begin st_d.out = 1'b1; st_d.run = 1'b0; end
                endcase
            end
        end else if (st_q.valid && gate_rise && is_edge_mode(st_q.mode)) begin
            st_d.cnt   = st_q.init;
            st_d.run   = 1'b1;
            st_d.fired = 1'b0;
            st_d.out   = (st_q.mode == M_SQUARE);
        end else if (st_q.valid && tick_i && st_q.run && level_ok) begin
            unique case (st_q.mode)
                M_ONESHOT, M_RETRIG: begin
                    st_d.cnt = cnt_dn1;
                    if (cnt_dn1 == '0) st_d.out = 1'b1;
                end
                M_SWSTROBE, M_HWSTROBE: begin
                    st_d.cnt = cnt_dn1;
                    if ((cnt_dn1 == '0) && !st_q.fired) begin
                        st_d.out   = 1'b1;
                        st_d.fired = 1'b1;
                    end else begin
                        st_d.out = 1'b0;
                    end
                end
                M_RATE: begin
                    if (st_q.cnt == CW'(1)) begin
                        st_d.cnt = st_q.init;
                        st_d.out = 1'b1;
                    end else begin
                        st_d.cnt = cnt_dn1;
                        st_d.out = 1'b0;
                    end
                end
                M_SQUARE: begin
                    if (half_end) begin
                        st_d.out = !st_q.out;
                        // Low half of an odd count is one shorter.
                        st_d.cnt = (st_q.out && st_q.init[0]) ? init_dn1 : st_q.init;
                    end else begin
                        st_d.cnt = cnt_dn2;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.init  <= '0;
            st_q.mode  <= M_ONESHOT;
            st_q.bcd   <= 1'b0;
            st_q.valid <= 1'b0;
            st_q.out   <= 1'b1;
            st_q.run   <= 1'b0;
            st_q.fired <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign out_o   = st_q.out;

    // Unprogrammed channel keeps its output high.
    p_unprog_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.valid |-> out_o);

    // One-shot output, once high, stays high until the next load.
    p_oneshot_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.valid && st_q.mode == M_ONESHOT && out_o && !load_i) |=> out_o);

    // Low gate freezes the count in level-gated modes.
    p_gate_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.valid && is_level_mode(st_q.mode) && !gate_i && !load_i)
        |=> $stable(count_o));

    // An untriggered gate-started one-shot does not count.
    p_wait_trigger_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.valid && st_q.mode == M_RETRIG && !st_q.run && !load_i && !gate_rise)
        |=> $stable(count_o));

    // Strobe pulses last one tick period.
    p_strobe_narrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.valid && out_o && tick_i && !load_i &&
         ((st_q.mode == M_SWSTROBE && gate_i) || st_q.mode == M_HWSTROBE))
        |=> !out_o);

    for (genvar g = 0; g < DIGITS; g++) begin : g_bcd_chk
        // Decimal digits stay in range.
        p_bcd_digit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.valid && st_q.bcd) |-> (st_q.cnt[4*g +: 4] <= 4'd9));
    end
endmodule

// File: tb/interval_counter_tb.sv
module interval_counter_tb_top;
    localparam int CW  = 16;
    localparam int NV  = 54;
    localparam int WDG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [CW-1:0] init = '0;
    logic [2:0]    mode = '0;
    logic          bcd = 1'b0;
    logic          gate = 1'b1;
    logic          tick = 1'b0;
    logic [CW-1:0] count;
    logic          out;

    int total = 0;
    int bad   = 0;

    always #10 clk = !clk;

    interval_counter dut_i (
        .clk_i (clk), .rst_ni (rst_n), .load_i (load), .init_i (init),
        .mode_i (mode), .bcd_i (bcd), .gate_i (gate), .tick_i (tick),
        .count_o (count), .out_o (out)
    );

    // {req[4], load, mode[3], bcd, gate, tick, init[16], exp_cnt[16], exp_out}
    localparam logic [43:0] VEC [NV] = '{
        {4'd2,  1'b1,3'd0,1'b0,1'b1,1'b0,16'h0003,16'h0003,1'b0}, // R2 load
        {4'd2,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R2
        {4'd2,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R2
        {4'd2,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b1}, // R2 terminal
        {4'd2,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'hFFFF,1'b1}, // R2 wrap
        {4'd5,  1'b1,3'd2,1'b0,1'b1,1'b0,16'h0002,16'h0002,1'b0}, // R5 load
        {4'd5,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R5
        {4'd5,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b1}, // R5 pulse
        {4'd5,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R5
        {4'd5,  1'b0,3'd0,1'b0,1'b1,1'b0,16'h0000,16'h0001,1'b0}, // R5 no tick
        {4'd5,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b1}, // R5 pulse
        {4'd6,  1'b1,3'd3,1'b0,1'b1,1'b0,16'h0005,16'h0005,1'b1}, // R6 load
        {4'd6,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0003,1'b1}, // R6
        {4'd6,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b1}, // R6
        {4'd6,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0004,1'b0}, // R6 low half
        {4'd6,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R6
        {4'd6,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0005,1'b1}, // R6 high half
        {4'd10, 1'b1,3'd0,1'b1,1'b1,1'b0,16'h0010,16'h0010,1'b0}, // R10 load
        {4'd10, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0009,1'b0}, // R10 borrow
        {4'd3,  1'b0,3'd0,1'b0,1'b0,1'b1,16'h0000,16'h0009,1'b0}, // R3 paused
        {4'd3,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0008,1'b0}, // R3 no restart
        {4'd4,  1'b1,3'd1,1'b0,1'b1,1'b0,16'h0002,16'h0002,1'b1}, // R4 load
        {4'd4,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b1}, // R4 waits
        {4'd4,  1'b0,3'd0,1'b0,1'b0,1'b0,16'h0000,16'h0002,1'b1}, // R4
        {4'd4,  1'b0,3'd0,1'b0,1'b1,1'b0,16'h0000,16'h0002,1'b0}, // R4 trigger
        {4'd4,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R4
        {4'd4,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b1}, // R4 terminal
        {4'd4,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'hFFFF,1'b1}, // R4 wrap
        {4'd7,  1'b1,3'd5,1'b0,1'b1,1'b0,16'h0001,16'h0001,1'b0}, // R7 load
        {4'd7,  1'b0,3'd0,1'b0,1'b0,1'b0,16'h0000,16'h0001,1'b0}, // R7
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b0,16'h0000,16'h0001,1'b0}, // R7 trigger
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b1}, // R7 strobe
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'hFFFF,1'b0}, // R7
        {4'd7,  1'b1,3'd4,1'b0,1'b1,1'b0,16'h0002,16'h0002,1'b0}, // R7 load
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R7
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b1}, // R7 strobe
        {4'd7,  1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'hFFFF,1'b0}, // R7
        {4'd12, 1'b1,3'd6,1'b0,1'b1,1'b0,16'h0003,16'h0003,1'b0}, // R12 alias
        {4'd12, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R12
        {4'd12, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R12
        {4'd12, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0003,1'b1}, // R12 pulse
        {4'd11, 1'b1,3'd6,1'b0,1'b1,1'b0,16'h0005,16'h0003,1'b1}, // R11 deferred
        {4'd11, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R11
        {4'd11, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R11
        {4'd11, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0005,1'b1}, // R11 new value
        {4'd11, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0004,1'b0}, // R11
        {4'd8,  1'b0,3'd0,1'b0,1'b0,1'b0,16'h0000,16'h0004,1'b0}, // R8
        {4'd8,  1'b0,3'd0,1'b0,1'b1,1'b0,16'h0000,16'h0005,1'b0}, // R8 restart
        {4'd10, 1'b1,3'd0,1'b1,1'b1,1'b0,16'h0001,16'h0001,1'b0}, // R10 load
        {4'd10, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0000,1'b1}, // R10
        {4'd10, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h9999,1'b1}, // R10 wrap
        {4'd10, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h9998,1'b1}, // R10
        {4'd11, 1'b1,3'd0,1'b1,1'b1,1'b0,16'h0004,16'h0004,1'b0}, // R11 restart
        {4'd11, 1'b0,3'd0,1'b0,1'b1,1'b1,16'h0000,16'h0003,1'b0}  // R11
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int req, input logic [CW-1:0] exp_c, input logic exp_o);
        total++;
        if (count !== exp_c || out !== exp_o) begin
            bad++;
            $display("FAIL R%0d: count=%h out=%b expected count=%h out=%b",
                     req, count, out, exp_c, exp_o);
        end
    endtask

    task automatic drive(input logic l, input logic [2:0] m, input logic b,
                         input logic g, input logic t, input logic [CW-1:0] v);
        load = l; mode = m; bcd = b; gate = g; tick = t; init = v;
    endtask

    function automatic logic bcd_ok(input logic [CW-1:0] v);
        for (int k = 0; k < CW / 4; k++) if (v[4*k +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_max(input int req, input logic b, input int period);
        int misses = 0;
        drive(1'b1, 3'd2, b, 1'b1, 1'b0, '0);
        step();
        drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, '0);
        for (int k = 1; k <= period; k++) begin
            step();
            if (out !== (k == period)) misses++;
            if (b && !bcd_ok(count)) misses++;
        end
        // R9: pulse exactly at the maximum count, reload value is 0
        total++;
        if (misses != 0 || count !== '0) begin
            bad++;
            $display("FAIL R%0d: misses=%0d count=%h expected misses=0 count=0000",
                     req, misses, count);
        end
        tick = 1'b0;
    endtask

    initial begin
        #(WDG * 20);
        total++;
        bad++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 16'h0000, 1'b1);            // R1 reset state
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, '0);
        step();
        drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, '0);
        step();
        check(1, 16'h0000, 1'b1);            // R1 ticks and gate ignored

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][39], VEC[i][38:36], VEC[i][35], VEC[i][34],
                  VEC[i][33], VEC[i][32:17]);
            step();
            check(int'(VEC[i][43:40]), VEC[i][16:1], VEC[i][0]);
        end

        run_max(9, 1'b0, 65536);             // R9 binary maximum
        run_max(9, 1'b1, 10000);             // R9 and R10 decimal maximum

        // R6 with R10: square wave in decimal steps by two
        drive(1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 16'h0010);
        step();
        check(6, 16'h0010, 1'b1);
        drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, '0);
        step(); check(10, 16'h0008, 1'b1);
        step(); check(6, 16'h0006, 1'b1);
        step(); check(6, 16'h0004, 1'b1);
        step(); check(6, 16'h0002, 1'b1);
        step(); check(6, 16'h0010, 1'b0);
        step(); check(6, 16'h0008, 1'b0);
        // R8: rising gate restarts the square wave high
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, '0);
        step(); check(8, 16'h0008, 1'b0);
        gate = 1'b1;
        step(); check(8, 16'h0010, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule